// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a linear address. It takes one request at a time. A request in real mode is resolved by arithmetic alone: the selector is shifted left by four bits, the offset is added, and the sum is cut to 20 bits. A request in protected mode decodes the selector and reads the 8-byte descriptor it names as two 32-bit words, one from each of two reads. The reads come from either the global or the local descriptor table. The block then checks the descriptor and returns a linear address or a fault code.

The controller is a state machine with six states. `IDLE` waits for a request. `REQ_LO` offers the read of the low descriptor word and `WAIT_LO` waits for its data. `REQ_HI` and `WAIT_HI` do the same for the high word. `DONE` presents the response for one cycle. The transitions are:
- `accept_fast` goes from `IDLE` to `DONE` for a real-mode or null-selector request.
- `accept_walk` goes from `IDLE` to `REQ_LO` for any other request.
- `lo_issued` goes from `REQ_LO` to `WAIT_LO` when the port takes the read.
- `lo_data` goes from `WAIT_LO` to `REQ_HI` when the read data arrives.
- `hi_issued` goes from `REQ_HI` to `WAIT_HI`.
- `hi_data` goes from `WAIT_HI` to `DONE`.
- `release` goes from `DONE` to `IDLE`.

The table bases must stay stable while a request is in flight.

Top module: `seg_xlate_top`

## Requirements
- R1: With `req_real_mode`=1, the response has fault 0 and `rsp_lin` = zero-extended ((selector << 4) + offset) mod 2^20, and no memory read is issued.
- R2: The selector is decoded as follows. Bits 15:3 are the index. Bit 2 picks the table base: 0 picks `tbl_glb_base` and 1 picks `tbl_loc_base`. Bits 1:0 are the requester level. The low word is read at base + index*8 and the high word at base + index*8 + 4, in that order.
- R3: In protected mode, a selector whose bits 15:2 are all zero faults with code 1 (absent) and issues no memory read. Index 0 with bit 2 = 1 is a normal local-table access.
- R4: The descriptor fields are placed as follows.
  - Base bits 15:0 come from low word bits 31:16, base bits 23:16 from high word bits 7:0, and base bits 31:24 from high word bits 31:24.
  - Limit bits 15:0 come from low word bits 15:0, and limit bits 19:16 from high word bits 19:16.
  - In the high word, the granularity flag is bit 23, the present flag is bit 15, the level field is bits 14:13, and the code/data flag is bit 12.
- R5: A descriptor with present flag 0, or with code/data flag 0 (system segment), faults with code 1.
- R6: The effective limit is the 20-bit limit when granularity is 0, and limit*4096 + 4095 when granularity is 1. An offset above the effective limit faults with code 2. An offset equal to it passes.
- R7: If the current level (`req_cpl`) or the requester level is numerically greater than the descriptor level, the response faults with code 3.
- R8: When several checks fail, the fault codes take priority in the order 1, then 3, then 2.
- R9: A request that passes every check returns fault 0 and `rsp_lin` = (base + offset) mod 2^32. A response with any fault has `rsp_lin` = 0.
- R10: The handshake with the requester works as follows.
  - A request is accepted in a cycle where `req_valid` is high and `busy` is low.
  - `busy` is high from the cycle after acceptance through the cycle in which `rsp_valid` is high.
  - `rsp_valid` is a single-cycle pulse.
  - `req_valid` has no effect while `busy` is high.
- R11: A read is offered with `mem_req_valid` and holds its address until `mem_req_ready` is high. The unit then waits for `mem_rsp_valid` before it continues, however long the read takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_real_mode | input | 1 | 1 selects real-mode arithmetic |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset |
| req_cpl | input | 2 | Current privilege level |
| tbl_glb_base | input | 32 | Global table base address |
| tbl_loc_base | input | 32 | Local table base address |
| busy | output | 1 | Request in flight |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 limit, 3 privilege |
| rsp_lin | output | 32 | Linear address (0 on fault) |

## Verification
Real-mode requests with the largest selector and offset show whether the carry past 20 bits is dropped. Null and near-null selectors show whether the null test looks at the table bit as well as the index. Offsets exactly at and one past the effective limit, under both granularities, separate the byte scaling from the 4 KiB scaling and catch an off-by-one in the comparison. Descriptors that fail several checks at once expose the fault priority, and a base near the top of memory shows the wrap. Random descriptors, levels and offsets are also driven while the read port stalls and answers with varying delays. Extra request strobes are sent while the unit is busy, to show that they are ignored.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LIM_W     = 20;
    localparam int PAGE_BITS = 12;
    localparam int SEL_SHIFT = 4;
    localparam int DESC_LOG2 = 3;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_PRIV   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [12:0] idx;
        logic        tbl;
        logic [1:0]  rpl;
    } sel_t;

    typedef struct packed {
        logic [31:0]      base;
        logic [LIM_W-1:0] limit;
        logic             gran;
        logic             present;
        logic             code_data;
        logic [1:0]       dpl;
    } desc_t;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlate_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [15:0]   sel,
    input  logic [AW-1:0] glb_base,
    input  logic [AW-1:0] loc_base,
    output logic [1:0]    rpl,
    output logic          is_null,
    output logic [AW-1:0] desc_addr
);
    localparam int IDX_W = 13;

    sel_t          s;
    logic [AW-1:0] tbl_base;
    logic [AW-1:0] offs;

    always_comb begin
        s         = sel_t'(sel);
        rpl       = s.rpl;
        is_null   = (s.idx == '0) && !s.tbl;
        tbl_base  = s.tbl ? loc_base : glb_base;
        offs      = AW'({s.idx, {DESC_LOG2{1'b0}}});
        desc_addr = tbl_base + offs;
    end

    logic unused_w;
    assign unused_w = ^{IDX_W};

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_xlate_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [31:0]   w_lo,
    input  logic [31:0]   w_hi,
    input  logic [AW-1:0] off,
    input  logic [1:0]    cpl,
    input  logic [1:0]    rpl,
    output fault_e        fault,
    output logic [AW-1:0] lin
);
    desc_t         d;
    logic [AW-1:0] eff_lim;
    logic          absent, priv_bad, over;

    always_comb begin
        d.base      = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
        d.limit     = {w_hi[19:16], w_lo[15:0]};
        d.gran      = w_hi[23];
        d.present   = w_hi[15];
        d.dpl       = w_hi[14:13];
        d.code_data = w_hi[12];
    end

    always_comb begin
        eff_lim  = d.gran ? AW'({d.limit, {PAGE_BITS{1'b1}}}) : AW'(d.limit);
        absent   = !d.present || !d.code_data;
        priv_bad = (cpl > d.dpl) || (rpl > d.dpl);
        over     = off > eff_lim;
        if (absent)        fault = FLT_ABSENT;
        else if (priv_bad) fault = FLT_PRIV;
        else if (over)     fault = FLT_LIMIT;
        else               fault = FLT_NONE;
        lin = (fault == FLT_NONE) ? AW'(d.base) + off : '0;
    end

    logic unused_bits;
    assign unused_bits = ^{w_hi[22:20], w_hi[11:8]};

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int AW      = 32,
    parameter int REAL_AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_real_mode,
    input  logic [15:0]   req_sel,
    input  logic [AW-1:0] req_off,
    input  logic [1:0]    req_cpl,
    input  logic [AW-1:0] tbl_glb_base,
    input  logic [AW-1:0] tbl_loc_base,
    output logic          busy,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          rsp_valid,
    output logic [1:0]    rsp_fault,
    output logic [AW-1:0] rsp_lin
);
    localparam int HI_OFS = 4;

    state_e        state, nxt;
    logic          real_q, null_q;
    logic [15:0]   sel_q;
    logic [AW-1:0] off_q, daddr_q;
    logic [1:0]    cpl_q, rpl_q;
    logic [31:0]   wlo_q, whi_q;

    logic [1:0]    dec_rpl;
    logic          dec_null;
    logic [AW-1:0] dec_addr;
    fault_e        chk_fault;
    logic [AW-1:0] chk_lin;
    logic [REAL_AW-1:0] real_sum;

    seg_sel_decode #(.AW(AW)) u_dec (
        .sel       (req_sel),
        .glb_base  (tbl_glb_base),
        .loc_base  (tbl_loc_base),
        .rpl       (dec_rpl),
        .is_null   (dec_null),
        .desc_addr (dec_addr)
    );

    seg_desc_check #(.AW(AW)) u_chk_desc (
        .w_lo  (wlo_q),
        .w_hi  (whi_q),
        .off   (off_q),
        .cpl   (cpl_q),
        .rpl   (rpl_q),
        .fault (chk_fault),
        .lin   (chk_lin)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = (req_real_mode || dec_null) ? ST_DONE : ST_REQ_LO;
            ST_REQ_LO:  if (mem_req_ready) nxt = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rsp_valid) nxt = ST_REQ_HI;
            ST_REQ_HI:  if (mem_req_ready) nxt = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rsp_valid) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request and descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            real_q  <= 1'b0;
            null_q  <= 1'b0;
            sel_q   <= '0;
            off_q   <= '0;
            cpl_q   <= '0;
            rpl_q   <= '0;
            daddr_q <= '0;
            wlo_q   <= '0;
            whi_q   <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                real_q  <= req_real_mode;
                null_q  <= dec_null;
                sel_q   <= req_sel;
                off_q   <= req_off;
                cpl_q   <= req_cpl;
                rpl_q   <= dec_rpl;
                daddr_q <= dec_addr;
            end
            if (state == ST_WAIT_LO && mem_rsp_valid) wlo_q <= mem_rsp_data;
            if (state == ST_WAIT_HI && mem_rsp_valid) whi_q <= mem_rsp_data;
        end
    end

    assign real_sum = REAL_AW'({sel_q, {SEL_SHIFT{1'b0}}}) + off_q[REAL_AW-1:0];

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        mem_req_valid = (state == ST_REQ_LO) || (state == ST_REQ_HI);
        mem_req_addr  = (state == ST_REQ_HI) ? daddr_q + AW'(HI_OFS) : daddr_q;
        rsp_valid     = (state == ST_DONE);
        if (real_q) begin
            rsp_fault = FLT_NONE;
            rsp_lin   = AW'(real_sum);
        end else if (null_q) begin
            rsp_fault = FLT_ABSENT;
            rsp_lin   = '0;
        end else begin
            rsp_fault = chk_fault;
            rsp_lin   = chk_lin;
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          rsp_valid,
    input logic [1:0]    rsp_fault,
    input logic [AW-1:0] rsp_lin
);
    p_rsp_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_rd_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_fault_zero_lin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_lin == '0));

endmodule

bind seg_xlate_top seg_xlate_chk #(.AW(AW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_lin       (rsp_lin)
);

// File: tb/seg_xlate_top_tb.sv
`timescale 1ns/1ps
module seg_xlate_top_tb;

    localparam logic [31:0] GB = 32'h0001_0000;
    localparam logic [31:0] LB = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_real_mode;
    logic [15:0] req_sel;
    logic [31:0] req_off;
    logic [1:0]  req_cpl;
    logic        busy, mem_req_valid, mem_req_ready, mem_rsp_valid, rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data, rsp_lin;
    logic [1:0]  rsp_fault;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] gdt_w [0:15];
    logic [31:0] ldt_w [0:15];

    int          rd_cnt;
    logic [31:0] rd_addr [0:1];
    int          pend_cnt = 0;
    logic [31:0] pend_data;

    always #4 clk = ~clk;

    seg_xlate_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_real_mode(req_real_mode),
        .req_sel(req_sel), .req_off(req_off), .req_cpl(req_cpl),
        .tbl_glb_base(GB), .tbl_loc_base(LB), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= GB && a < GB + 64) return gdt_w[(a - GB) >> 2];
        if (a >= LB && a < LB + 64) return ldt_w[(a - LB) >> 2];
        return 32'hDEAD_BEEF;
    endfunction

    task automatic set_desc(input bit tbl, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input bit g, input bit p,
                            input bit s, input logic [1:0] dpl);
        logic [31:0] lo, hi;
        lo = {base[15:0], lim[15:0]};
        hi = {base[31:24], g, 3'b0, lim[19:16], p, dpl, s, 4'b0, base[23:16]};
        if (tbl) begin ldt_w[idx*2] = lo; ldt_w[idx*2+1] = hi; end
        else     begin gdt_w[idx*2] = lo; gdt_w[idx*2+1] = hi; end
    endtask

    // reference model built from the requirement text
    task automatic model(input bit rm, input logic [15:0] sel, input logic [31:0] off,
                         input logic [1:0] cpl, output logic [1:0] f,
                         output logic [31:0] l, output int nrd, output logic [31:0] a0);
        logic [31:0] lo, hi, base, eff;
        logic [19:0] lim;
        logic [1:0]  dpl;
        a0 = (sel[2] ? LB : GB) + {16'b0, sel[15:3], 3'b0};
        f = 2'd0; l = 32'd0; nrd = 2;
        if (rm) begin
            l = {12'b0, 20'({sel, 4'b0} + off[19:0])};
            nrd = 0;
            return;
        end
        if (sel[15:2] == 0) begin f = 2'd1; nrd = 0; return; end
        lo = mem_word(a0); hi = mem_word(a0 + 4);
        base = {hi[31:24], hi[7:0], lo[31:16]};
        lim  = {hi[19:16], lo[15:0]};
        dpl  = hi[14:13];
        eff  = hi[23] ? ({12'b0, lim} * 4096 + 4095) : {12'b0, lim};
        if (!hi[15] || !hi[12])            f = 2'd1;
        else if (cpl > dpl || sel[1:0] > dpl) f = 2'd3;
        else if (off > eff)                f = 2'd2;
        else                               l = base + off;
    endtask

    // memory port model: random ready, 1..3 cycle read latency
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = pend_data; end
            end
            mem_req_ready = ($urandom % 3) != 0;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
                pend_data = mem_word(mem_req_addr);
                pend_cnt  = 1 + ($urandom % 3);
            end
        end
    end

    task automatic xlate(input string tag, input bit rm, input logic [15:0] sel,
                         input logic [31:0] off, input logic [1:0] cpl, input bit junk);
        logic [1:0]  ef;
        logic [31:0] el, ea;
        int          enrd, wait_n;
        model(rm, sel, off, cpl, ef, el, enrd, ea);
        @(negedge clk);
        check("R10 idle before request", {31'b0, busy}, 32'd0);
        rd_cnt = 0;
        req_valid = 1; req_real_mode = rm; req_sel = sel; req_off = off; req_cpl = cpl;
        @(negedge clk);
        req_valid = 0;
        check("R10 busy after accept", {31'b0, busy}, 32'd1);
        wait_n = 0;
        while (!rsp_valid && wait_n < 200) begin
            if (busy !== 1'b1) check("R10 busy held", {31'b0, busy}, 32'd1);
            if (junk) begin
                req_valid = 1; req_real_mode = $urandom; req_sel = $urandom;
                req_off = $urandom; req_cpl = $urandom;
            end
            @(negedge clk);
            wait_n++;
        end
        req_valid = 0;
        check({tag, " response seen"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, ef});
        check({tag, " linear"}, rsp_lin, el);
        check("R11 read count", rd_cnt, enrd);
        if (enrd == 2) begin
            check("R2 low word addr", rd_addr[0], ea);
            check("R2 high word addr", rd_addr[1], ea + 4);
        end
        @(negedge clk);
        check("R10 pulse ends", {30'b0, busy, rsp_valid}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin gdt_w[i] = 0; ldt_w[i] = 0; end
        rst_n = 0; req_valid = 0; req_real_mode = 0; req_sel = 0; req_off = 0; req_cpl = 0;
        repeat (3) @(negedge clk);
        check("R10 reset busy", {31'b0, busy}, 32'd0);
        check("R10 reset rsp", {31'b0, rsp_valid}, 32'd0);
        check("R11 reset read", {31'b0, mem_req_valid}, 32'd0);
        rst_n = 1;

        // R1 real mode, carry beyond 20 bits dropped
        xlate("R1 real max", 1, 16'hFFFF, 32'h0000_FFFF, 0, 0);
        xlate("R1 real plain", 1, 16'h1234, 32'hABCD_0010, 3, 0);
        // R3 null selector, and local index 0 is not null (R2)
        xlate("R3 null", 0, 16'h0003, 32'h10, 0, 0);
        set_desc(1, 0, 32'h0040_0000, 20'hFFFFF, 0, 1, 1, 3);
        xlate("R2 local idx0", 0, 16'h0004, 32'h20, 0, 0);
        // R4 field placement, R6 byte granularity boundary
        set_desc(0, 1, 32'h1234_5678, 20'h0FFFF, 0, 1, 1, 0);
        xlate("R4 base", 0, 16'h0008, 32'h0000_0001, 0, 0);
        xlate("R6 byte at limit", 0, 16'h0008, 32'h0000_FFFF, 0, 0);
        xlate("R6 byte over", 0, 16'h0008, 32'h0001_0000, 0, 0);
        // R6 page granularity boundary
        set_desc(0, 2, 32'h0800_0000, 20'h00001, 1, 1, 1, 0);
        xlate("R6 page at limit", 0, 16'h0010, 32'h0000_1FFF, 0, 0);
        xlate("R6 page over", 0, 16'h0010, 32'h0000_2000, 0, 0);
        // R5 absent and system
        set_desc(0, 3, 32'h0, 20'hFFFFF, 1, 0, 1, 3);
        xlate("R5 not present", 0, 16'h0018, 32'h0, 0, 0);
        set_desc(0, 4, 32'h0, 20'hFFFFF, 1, 1, 0, 3);
        xlate("R5 system seg", 0, 16'h0020, 32'h0, 0, 0);
        // R7 privilege
        set_desc(1, 5, 32'h0009_0000, 20'hFFFFF, 0, 1, 1, 2);
        xlate("R7 cpl high", 0, 16'h002E, 32'h4, 3, 0);
        xlate("R7 rpl high", 0, 16'h002F, 32'h4, 1, 0);
        xlate("R7 equal ok", 0, 16'h002E, 32'h4, 2, 0);
        // R8 priority
        set_desc(0, 6, 32'h0, 20'h00000, 0, 0, 1, 0);
        xlate("R8 absent first", 0, 16'h0033, 32'hFFFF, 3, 0);
        set_desc(0, 6, 32'h0, 20'h00000, 0, 1, 1, 0);
        xlate("R8 priv before limit", 0, 16'h0033, 32'hFFFF, 3, 0);
        // R9 wrap
        set_desc(0, 7, 32'hFFFF_FF00, 20'hFFFFF, 1, 1, 1, 3);
        xlate("R9 wrap", 0, 16'h0038, 32'h0000_0200, 0, 0);
        // R10 strobes while busy are ignored
        xlate("R10 ignore busy protected", 0, 16'h0038, 32'h0000_0010, 1, 1);
        xlate("R10 ignore busy real", 1, 16'h0F00, 32'h0000_0123, 0, 1);

        // random mix
        for (int n = 0; n < 250; n++) begin
            bit          t, g, rm;
            int          ix;
            logic [19:0] lim;
            logic [31:0] eff, off;
            t = $urandom; ix = $urandom % 8; g = $urandom; rm = ($urandom % 7) == 0;
            lim = ($urandom % 2) ? 20'($urandom % 64) : 20'($urandom);
            set_desc(t, ix, $urandom, lim, g, ($urandom % 10) != 0,
                     ($urandom % 10) != 0, 2'($urandom));
            eff = g ? {12'b0, lim} * 4096 + 4095 : {12'b0, lim};
            case ($urandom % 3)
                0:       off = eff;
                1:       off = eff + 1;
                default: off = $urandom % (eff + 1);
            endcase
            xlate("RAND R9 mix", rm, {13'(ix), t, 2'($urandom)}, off, 2'($urandom), n % 5 == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule